// File: doc/BRIEF.md
# Manchester II Word Encoder

This block sends serial command and data words for a dual-redundant 1 Mbit/s avionics bus. It runs from a 12 MHz clock, so one bit time is 12 clocks. Each word takes 20 bit times, or 240 clocks. A word starts with a three-bit-time sync pattern. Sixteen Manchester-coded data bits follow, most significant bit first, and the word ends with an odd parity bit that the block computes itself. The serial level is driven onto one of two complementary output pairs, bus A or bus B. Each bus has its own transmit disable, which silences that bus while the timing keeps running.

The host offers words on a valid/ready write port. A word is taken on a rising edge where `wr_valid` and `wr_ready` are both high. The host may hold `wr_valid` high for as long as it likes. While `wr_ready` is low nothing is taken, and the data, sync type and bus selection must stay stable until the word is taken. When the encoder is idle, a taken word goes straight into the shift register and starts on the next clock. While a word is being sent, `wr_ready` opens 3.5 bit times after that word began and closes 18.5 bit times after it began. A word taken in that window waits in a holding register and goes out right after the current word, with no gap. Once a word is waiting, `wr_ready` stays low until the next window.

Top module: `mil_word_encoder`

## Requirements
- R1: A bit time lasts 12 clocks and a whole word lasts 240 clocks. The first clock of a word is clock 0.
- R2: With `wr_cmd_sync`=1, the sync is the positive level (pos output high) for clocks 0 to 17 and the negative level (neg output high) for clocks 18 to 35. With `wr_cmd_sync`=0 the two halves are swapped.
- R3: Data bit 15 is sent first, in clocks 36 to 47, and bit 0 is sent last. A 1 bit is positive for the first 6 clocks of its bit time and negative for the last 6. A 0 bit is negative then positive.
- R4: Clocks 228 to 239 carry a parity bit, coded like a data bit, that makes the count of ones across the 16 data bits and the parity bit odd.
- R5: After reset, and whenever idle, all four drive outputs are low and `wr_ready` is 1. A word taken while idle shows its first sync clock (clock 0) in the cycle after the taking edge.
- R6: While a word is being sent, `wr_ready` is 1 only in clocks 42 to 221 of that word, and only while no word is waiting. It drops in the cycle after a word is taken.
- R7: A waiting word begins at the clock after clock 239 of the current word, with no gap. If no word is waiting, the encoder goes idle after clock 239.
- R8: `wr_bus_b`=0 selects bus A and 1 selects bus B. The bus selection, data and sync type are captured at the taking edge. Later changes to these inputs do not affect the word.
- R9: While `tx_dis_a` (or `tx_dis_b`) is 1, both outputs of that bus stay low. Word timing and `wr_ready` behave exactly as when the bus is enabled.
- R10: At most one of the four drive outputs is high in any cycle, and the bus that was not selected stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host offers a word |
| wr_ready | output | 1 | Encoder can take a word |
| wr_data | input | 16 | Word payload, bit 15 sent first |
| wr_cmd_sync | input | 1 | 1 selects command sync, 0 selects data sync |
| wr_bus_b | input | 1 | 0 selects bus A, 1 selects bus B |
| tx_dis_a | input | 1 | Silences bus A outputs |
| tx_dis_b | input | 1 | Silences bus B outputs |
| bus_a_pos | output | 1 | Bus A positive drive |
| bus_a_neg | output | 1 | Bus A negative drive |
| bus_b_pos | output | 1 | Bus B positive drive |
| bus_b_neg | output | 1 | Bus B negative drive |

## Verification
The key coincidence is the word boundary of a back-to-back pair. In the same clock, the last parity half-bit of one word finishes, the holding register moves into the shift register, and the new word's sync begins. The bench provokes this by queuing a second and a third word while the first is still being sent, including one pair that switches from bus A to bus B. A per-clock scoreboard then expects clock 0 of the next word right after clock 239 of the previous one, and expects `wr_ready` to stay closed while a word waits. A second overlap is a word being taken into the holding register while the shifter is moving data bits. This is judged by the fact that the word in flight keeps its exact waveform.

// File: rtl/mil_enc_pkg.sv
package mil_enc_pkg;
  localparam int unsigned SYNC_SLOTS   = 3;
  localparam int unsigned PARITY_SLOTS = 1;

  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_DATA   = 2'd1,
    PH_PARITY = 2'd2
  } tx_phase_e;
endpackage

// File: rtl/mil_enc_bitclk.sv
module mil_enc_bitclk #(
  parameter int unsigned CLK_PER_BIT = 12,
  parameter int unsigned SLOTS       = 20,
  parameter int unsigned SYNC_SLOTS  = 3,
  localparam int unsigned SUB_W  = $clog2(CLK_PER_BIT),
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [SUB_W-1:0]  sub_cnt,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              second_half,
  output logic              slot_end,
  output logic              word_end,
  output logic              in_window
);
  localparam logic [SUB_W-1:0]  SUB_LAST   = SUB_W'(CLK_PER_BIT - 1);
  localparam logic [SUB_W-1:0]  SUB_HALF   = SUB_W'(CLK_PER_BIT / 2);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] OPEN_SLOT  = SLOT_W'(SYNC_SLOTS);
  localparam logic [SLOT_W-1:0] CLOSE_SLOT = SLOT_W'(SLOTS - 2);

  assign second_half = (sub_cnt >= SUB_HALF);
  assign slot_end    = run && (sub_cnt == SUB_LAST);
  assign word_end    = slot_end && (slot_cnt == SLOT_LAST);

  always_comb begin
    in_window = 1'b0;
    if (run) begin
      if (slot_cnt == OPEN_SLOT)       in_window = second_half;
      else if (slot_cnt == CLOSE_SLOT) in_window = !second_half;
      else                             in_window = (slot_cnt > OPEN_SLOT) && (slot_cnt < CLOSE_SLOT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sub_cnt  <= '0;
      slot_cnt <= '0;
    end else if (slot_end) begin
      sub_cnt  <= '0;
      slot_cnt <= word_end ? '0 : slot_cnt + 1'b1;
    end else begin
      sub_cnt  <= sub_cnt + 1'b1;
    end
  end

  // R1: the clock-in-bit counter never leaves its range
  a_r1_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub_cnt <= SUB_LAST);

  // R1: after the last clock of a word the slot count wraps to zero
  a_r1_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (slot_cnt == '0) && (sub_cnt == '0));
endmodule

// File: rtl/mil_enc_ctrl.sv
module mil_enc_ctrl
  import mil_enc_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLK_PER_BIT = 12,
  parameter int unsigned SLOTS       = 20,
  localparam int unsigned SUB_W  = $clog2(CLK_PER_BIT),
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cmd_sync,
  input  logic              wr_bus_b,
  input  logic [SUB_W-1:0]  sub_cnt,
  input  logic [SLOT_W-1:0] slot_cnt,
  input  logic              second_half,
  input  logic              slot_end,
  input  logic              word_end,
  input  logic              in_window,
  output logic              active,
  output logic              line_hi,
  output logic              bus_sel
);
  localparam logic [SLOT_W-1:0] DATA_FIRST = SLOT_W'(SYNC_SLOTS);
  localparam logic [SLOT_W-1:0] PAR_SLOT   = SLOT_W'(SYNC_SLOTS + DATA_W);

  logic [DATA_W-1:0] shift_q;
  logic              par_q, cmd_q;
  logic [DATA_W-1:0] hold_data;
  logic              hold_cmd, hold_bus, held;
  logic              accept;
  logic              sync_first;
  tx_phase_e         phase;

  assign wr_ready = !active || (in_window && !held);
  assign accept   = wr_valid && wr_ready;

  always_comb begin
    if (slot_cnt < DATA_FIRST)    phase = PH_SYNC;
    else if (slot_cnt < PAR_SLOT) phase = PH_DATA;
    else                          phase = PH_PARITY;
  end

  // sync occupies 1.5 bit times per polarity
  assign sync_first = (slot_cnt == '0) || ((slot_cnt == SLOT_W'(1)) && !second_half);

  always_comb begin
    unique case (phase)
      PH_SYNC: line_hi = cmd_q ? sync_first : !sync_first;
      PH_DATA: line_hi = shift_q[DATA_W-1] ^ second_half;
      default: line_hi = par_q ^ second_half;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      held      <= 1'b0;
      shift_q   <= '0;
      par_q     <= 1'b0;
      cmd_q     <= 1'b0;
      bus_sel   <= 1'b0;
      hold_data <= '0;
      hold_cmd  <= 1'b0;
      hold_bus  <= 1'b0;
    end else begin
      if (accept && !active) begin
        shift_q <= wr_data;
        par_q   <= ~^wr_data;
        cmd_q   <= wr_cmd_sync;
        bus_sel <= wr_bus_b;
        active  <= 1'b1;
      end else if (word_end) begin
        if (held) begin
          shift_q <= hold_data;
          par_q   <= ~^hold_data;
          cmd_q   <= hold_cmd;
          bus_sel <= hold_bus;
          held    <= 1'b0;
        end else begin
          active  <= 1'b0;
        end
      end else if (slot_end && (phase == PH_DATA)) begin
        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
      end
      if (accept && active) begin
        hold_data <= wr_data;
        hold_cmd  <= wr_cmd_sync;
        hold_bus  <= wr_bus_b;
        held      <= 1'b1;
      end
    end
  end

  // R5: a word taken while idle starts at clock 0 of a word on the next cycle
  a_r5_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !active) |=> (active && (slot_cnt == '0) && (sub_cnt == '0)));

  // R6: a waiting word keeps the write port closed
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !wr_ready);

  // R7: with nothing waiting the encoder goes idle after the last clock
  a_r7_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !held) |=> !active);

  // R7: a waiting word keeps the encoder busy across the boundary
  a_r7_gapless: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && held) |=> (active && !held));
endmodule

// File: rtl/mil_enc_drive.sv
module mil_enc_drive #(
  parameter int unsigned NBUS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            line_hi,
  input  logic            bus_sel,
  input  logic [NBUS-1:0] dis,
  output logic [NBUS-1:0] pos,
  output logic [NBUS-1:0] neg
);
  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    logic on;
    assign on     = active && (int'(bus_sel) == i) && !dis[i];
    assign pos[i] = on && line_hi;
    assign neg[i] = on && !line_hi;
  end

  // R10: never more than one drive line high
  a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pos, neg}) <= 1);
endmodule

// File: rtl/mil_word_encoder.sv
module mil_word_encoder #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLK_PER_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cmd_sync,
  input  logic              wr_bus_b,
  input  logic              tx_dis_a,
  input  logic              tx_dis_b,
  output logic              bus_a_pos,
  output logic              bus_a_neg,
  output logic              bus_b_pos,
  output logic              bus_b_neg
);
  import mil_enc_pkg::*;

  localparam int unsigned SLOTS  = SYNC_SLOTS + DATA_W + PARITY_SLOTS;
  localparam int unsigned SUB_W  = $clog2(CLK_PER_BIT);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic [SUB_W-1:0]  sub_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic second_half, slot_end, word_end, in_window;
  logic active, line_hi, bus_sel;
  logic [1:0] pos_v, neg_v;

  mil_enc_bitclk #(
    .CLK_PER_BIT(CLK_PER_BIT), .SLOTS(SLOTS), .SYNC_SLOTS(SYNC_SLOTS)
  ) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(active),
    .sub_cnt(sub_cnt), .slot_cnt(slot_cnt), .second_half(second_half),
    .slot_end(slot_end), .word_end(word_end), .in_window(in_window)
  );

  mil_enc_ctrl #(
    .DATA_W(DATA_W), .CLK_PER_BIT(CLK_PER_BIT), .SLOTS(SLOTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_cmd_sync(wr_cmd_sync), .wr_bus_b(wr_bus_b),
    .sub_cnt(sub_cnt), .slot_cnt(slot_cnt), .second_half(second_half),
    .slot_end(slot_end), .word_end(word_end), .in_window(in_window),
    .active(active), .line_hi(line_hi), .bus_sel(bus_sel)
  );

  mil_enc_drive #(.NBUS(2)) u_drive (
    .clk(clk), .rst_n(rst_n), .active(active), .line_hi(line_hi),
    .bus_sel(bus_sel), .dis({tx_dis_b, tx_dis_a}), .pos(pos_v), .neg(neg_v)
  );

  assign bus_a_pos = pos_v[0];
  assign bus_a_neg = neg_v[0];
  assign bus_b_pos = pos_v[1];
  assign bus_b_neg = neg_v[1];
endmodule

// File: tb/sim_mil_word_encoder.sv
module sim_mil_word_encoder;
  localparam int CLK_PERIOD = 84;
  localparam int WORD_CLKS  = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [15:0] wr_data = '0;
  logic wr_cmd_sync = 1'b0;
  logic wr_bus_b = 1'b0;
  logic tx_dis_a = 1'b0;
  logic tx_dis_b = 1'b0;
  logic bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;

  logic [15:0] q_data[$];
  bit          q_cmd[$];
  bit          q_bus[$];

  bit          run = 1'b0;
  int          pos = 0;
  logic [15:0] cur_d;
  bit          cur_c, cur_b;
  int          word_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mil_word_encoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_cmd_sync(wr_cmd_sync), .wr_bus_b(wr_bus_b),
    .tx_dis_a(tx_dis_a), .tx_dis_b(tx_dis_b),
    .bus_a_pos(bus_a_pos), .bus_a_neg(bus_a_neg),
    .bus_b_pos(bus_b_pos), .bus_b_neg(bus_b_neg)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit exp_level(input int p, input logic [15:0] d, input bit c);
    int  b = p / 12;
    bit  h = (p % 12) >= 6;
    if (b < 3)       return c ? (p < 18) : !(p < 18);
    else if (b < 19) return d[18 - b] ^ h;
    else             return (~^d) ^ h;
  endfunction

  function automatic string region_tag(input int p);
    if (p < 36)       return "R2";
    else if (p < 228) return "R3";
    else              return "R4";
  endfunction

  // driver: offer a word, hold it until taken, record it, then scramble inputs (R8)
  task automatic send(input logic [15:0] d, input bit c, input bit b);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_cmd_sync = c; wr_bus_b = b;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    q_data.push_back(d); q_cmd.push_back(c); q_bus.push_back(b);
    @(negedge clk);
    wr_valid = 1'b0; wr_data = ~d; wr_cmd_sync = ~c; wr_bus_b = ~b;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (run || q_data.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (started) begin
      logic [3:0] got, exp;
      bit lvl, on, exp_rdy;
      string tag;
      if (!run && q_data.size() != 0) begin
        cur_d = q_data.pop_front(); cur_c = q_cmd.pop_front(); cur_b = q_bus.pop_front();
        run = 1'b1; pos = 0; word_bad = 0;
      end
      got = {bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg};
      exp = 4'b0000;
      if (run) begin
        lvl = exp_level(pos, cur_d, cur_c);
        on  = !(cur_b ? tx_dis_b : tx_dis_a);
        if (on) exp = cur_b ? {2'b00, lvl, !lvl} : {lvl, !lvl, 2'b00};
        if (!on) tag = "R9";
        else if (got != exp && (cur_b ? (got[3:2] != 0) : (got[1:0] != 0))) tag = "R8";
        else tag = region_tag(pos);
        exp_rdy = (pos >= 42) && (pos <= 221) && (q_data.size() == 0);
        chk(got == exp, tag, $sformatf("drive at word clock %0d", pos), got, exp);
        chk(wr_ready == exp_rdy, "R6", $sformatf("wr_ready at word clock %0d", pos),
            {3'b0, wr_ready}, {3'b0, exp_rdy});
        chk($countones(got) <= 1, "R10", "more than one drive line high", got, exp);
        if (got != exp) word_bad++;
        pos++;
        if (pos == WORD_CLKS) begin
          // R1 and R7: whole 240-clock word matched before the next word or idle
          chk(word_bad == 0, "R1 R7", $sformatf("word %h mismatched clocks", cur_d),
              4'(word_bad), 4'd0);
          if (q_data.size() != 0) begin
            cur_d = q_data.pop_front(); cur_c = q_cmd.pop_front(); cur_b = q_bus.pop_front();
            pos = 0; word_bad = 0;
          end else begin
            run = 1'b0;
          end
        end
      end else begin
        chk(got == 4'b0000, "R5", "idle drive lines", got, 4'b0000);
        chk(wr_ready == 1'b1, "R5", "idle wr_ready", {3'b0, wr_ready}, 4'b0001);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    started = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4: single words, both syncs, both buses, extreme parity
    send(16'hA5C3, 1'b1, 1'b0); wait_idle();
    send(16'h0000, 1'b0, 1'b1); wait_idle();
    send(16'hFFFF, 1'b1, 1'b1); wait_idle();

    // R6 R7: three contiguous words, third held off until the window reopens
    send(16'h1234, 1'b0, 1'b0);
    send(16'h8001, 1'b1, 1'b0);
    send(16'h7FFE, 1'b0, 1'b0);
    wait_idle();

    // R9: disabled bus A stays silent, timing unchanged; bus B unaffected
    tx_dis_a = 1'b1;
    send(16'h5A5A, 1'b1, 1'b0); wait_idle();
    send(16'h3C3C, 1'b0, 1'b1); wait_idle();
    tx_dis_a = 1'b0; tx_dis_b = 1'b1;
    send(16'hC001, 1'b1, 1'b1);
    send(16'h0F0F, 1'b0, 1'b0);
    wait_idle();
    tx_dis_b = 1'b0;

    // R8: contiguous words switching bus A to bus B
    send(16'hBEEF, 1'b1, 1'b0);
    send(16'hCAFE, 1'b0, 1'b1);
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule